// File: doc/BRIEF.md
# Route Result Selector with ECMP Resolution

This block turns the results of two route searches into one forwarding decision for an IP unicast packet. It runs in parallel with the searches. One search is an exact-match table of full-length host routes. The other is a table of variable-length prefixes. Each search reports whether it hit, and the block decides which hit governs the packet. It reports that choice together with the effective match length.

A winning result is one of two kinds. It is either a direct adjacency pointer, or the base of an equal-cost group together with the group's size. For a group entry, the block reduces the packet's flow hash modulo the member count and adds that offset to the base. It then reads the member table at that address to obtain the adjacency pointer. The block next reads the adjacency store at the pointer and presents the next-hop record: output port, rewritten destination MAC and MTU. Both tables sit outside the block behind combinational read ports. If neither search hits, the result is a forwarding-miss drop.

Requests arrive on a valid/ready handshake, one per cycle. Results leave in request order two clock edges after acceptance. The whole pipeline stalls while a result waits for the consumer.

Top module: `route_select`

## Requirements
- R1: When the host search hits, it wins whether or not the prefix search hits: `out_src` = 1 and `out_plen` = 32 for IPv4 (`in_v6` = 0) or 128 for IPv6 (`in_v6` = 1).
- R2: When only the prefix search hits, `out_src` = 2 and `out_plen` equals `pfx_len` of that request.
- R3: When neither search hits, `out_drop` = 1 and `out_src` = 0. `out_multi`, `out_adj_ptr`, `out_port`, `out_dmac` and `out_mtu` are all 0.
- R4: For a single-path winner (multi flag 0), `out_adj_ptr` equals the winner's index. `out_port`, `out_dmac` and `out_mtu` are the adjacency-store record at that pointer.
- R5: For a multipath winner (multi flag 1), the winner's index is the group base and its group field holds the member count minus one. The member-table address is (base + hash mod (group field + 1)) modulo 2^ECMP_W. `out_adj_ptr` is the member-table entry at that address, `out_multi` = 1, and the record comes from the adjacency store at that pointer.
- R6: Two requests that carry the same flow hash and the same winning group resolve to the same adjacency pointer.
- R7: With `out_ready` held high, a request accepted at one clock edge appears with `out_valid` = 1 after the second following edge. Back-to-back requests are accepted every cycle and leave in order.
- R8: While `out_valid` = 1 and `out_ready` = 0, every output stays unchanged and `in_ready` = 0. No request is lost or duplicated.
- R9: After reset, `out_valid` = 0 and `in_ready` = 1.
- R10: `out_vrf` and `out_addr` return the VRF and destination address of the request the result belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge if valid |
| in_vrf | input | VRF_W | VRF of the lookup key |
| in_addr | input | ADDR_W | Destination address (IPv4 in low 32 bits) |
| in_v6 | input | 1 | Address family: 1 = IPv6 |
| in_hash | input | HASH_W | Flow hash |
| host_hit | input | 1 | Host search hit |
| host_multi | input | 1 | Host result is a group |
| host_idx | input | RES_W | Host result: adjacency pointer or group base |
| host_grp | input | GRP_W | Host group member count minus one |
| pfx_hit | input | 1 | Prefix search hit |
| pfx_len | input | PLEN_W | Matched prefix length |
| pfx_multi | input | 1 | Prefix result is a group |
| pfx_idx | input | RES_W | Prefix result: adjacency pointer or group base |
| pfx_grp | input | GRP_W | Prefix group member count minus one |
| ecmp_rd_addr | output | ECMP_W | Member-table read address |
| ecmp_rd_adj | input | ADJ_W | Member-table read data (adjacency pointer) |
| adj_rd_addr | output | ADJ_W | Adjacency-store read address |
| adj_rd_port | input | PORT_W | Adjacency record: output port |
| adj_rd_dmac | input | 48 | Adjacency record: destination MAC |
| adj_rd_mtu | input | MTU_W | Adjacency record: MTU |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_drop | output | 1 | Forwarding miss, drop |
| out_src | output | 2 | Winning table: 0 none, 1 host, 2 prefix |
| out_plen | output | PLEN_W | Effective match length |
| out_multi | output | 1 | Result resolved through a group |
| out_adj_ptr | output | ADJ_W | Chosen adjacency pointer |
| out_port | output | PORT_W | Next-hop output port |
| out_dmac | output | 48 | Next-hop destination MAC |
| out_mtu | output | MTU_W | Next-hop MTU |
| out_vrf | output | VRF_W | Echoed VRF |
| out_addr | output | ADDR_W | Echoed destination address |

## Verification
The hardest case to reach is a stall that freezes the pipeline while both internal stages hold live requests, one of them a multipath entry. A stall of this kind can lose a request or duplicate one. To create it, the bench first drains the pipeline and then streams requests back to back. Meanwhile it drops the consumer's ready for several cycles in an irregular pattern, so stalls begin and end with different mixes of group and direct entries in flight. Group wrap-around is reached by giving a base near the top of the member table. Modulo corners are reached with hashes that are exact multiples of the group size, with the all-ones hash, and with one-member groups.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_HOST   = 2'd1,
        SRC_PREFIX = 2'd2
    } win_src_e;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rrs_arbiter.sv
module rrs_arbiter
    import rrs_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int GRP_W     = 4,
    parameter int PLEN_W    = 8,
    parameter int V4_LEN    = 32,
    parameter int V6_LEN    = 128
) (
    input  logic              in_v6,
    input  logic              host_hit,
    input  logic              host_multi,
    input  logic [RES_W-1:0]  host_idx,
    input  logic [GRP_W-1:0]  host_grp,
    input  logic              pfx_hit,
    input  logic [PLEN_W-1:0] pfx_len,
    input  logic              pfx_multi,
    input  logic [RES_W-1:0]  pfx_idx,
    input  logic [GRP_W-1:0]  pfx_grp,
    output win_src_e          win_src,
    output logic [PLEN_W-1:0] win_len,
    output logic              win_multi,
    output logic [RES_W-1:0]  win_idx,
    output logic [GRP_W-1:0]  win_grp
);

    always_comb begin
        win_src   = SRC_NONE;
        win_len   = '0;
        win_multi = 1'b0;
        win_idx   = '0;
        win_grp   = '0;
        if (host_hit) begin
            win_src   = SRC_HOST;
            win_len   = in_v6 ? PLEN_W'(V6_LEN) : PLEN_W'(V4_LEN);
            win_multi = host_multi;
            win_idx   = host_idx;
            win_grp   = host_grp;
        end else if (pfx_hit) begin
            win_src   = SRC_PREFIX;
            win_len   = pfx_len;
            win_multi = pfx_multi;
            win_idx   = pfx_idx;
            win_grp   = pfx_grp;
        end
    end

endmodule

// File: rtl/rrs_ecmp_pick.sv
module rrs_ecmp_pick #(
    parameter int ECMP_W = 10,
    parameter int GRP_W  = 4,
    parameter int HASH_W = 16
) (
    input  logic [ECMP_W-1:0] base,
    input  logic [GRP_W-1:0]  grp,
    input  logic [HASH_W-1:0] hash,
    output logic [ECMP_W-1:0] member_addr
);

    localparam int OFF_W = GRP_W + 1;

    logic [HASH_W-1:0] span;
    logic [HASH_W-1:0] rem;
    logic [OFF_W-1:0]  offset;

    always_comb begin
        span        = HASH_W'(grp) + HASH_W'(1);
        rem         = hash % span;
        offset      = rem[OFF_W-1:0];
        member_addr = base + ECMP_W'(offset);
    end

endmodule

// File: rtl/route_select.sv
module route_select
    import rrs_pkg::*;
#(
    parameter int VRF_W  = 12,
    parameter int ADDR_W = 128,
    parameter int ADJ_W  = 10,
    parameter int ECMP_W = 10,
    parameter int GRP_W  = 4,
    parameter int HASH_W = 16,
    parameter int PORT_W = 8,
    parameter int MTU_W  = 14,
    localparam int RES_W  = int'(imax(ADJ_W, ECMP_W)),
    localparam int PLEN_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VRF_W-1:0]  in_vrf,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_v6,
    input  logic [HASH_W-1:0] in_hash,
    input  logic              host_hit,
    input  logic              host_multi,
    input  logic [RES_W-1:0]  host_idx,
    input  logic [GRP_W-1:0]  host_grp,
    input  logic              pfx_hit,
    input  logic [PLEN_W-1:0] pfx_len,
    input  logic              pfx_multi,
    input  logic [RES_W-1:0]  pfx_idx,
    input  logic [GRP_W-1:0]  pfx_grp,
    output logic [ECMP_W-1:0] ecmp_rd_addr,
    input  logic [ADJ_W-1:0]  ecmp_rd_adj,
    output logic [ADJ_W-1:0]  adj_rd_addr,
    input  logic [PORT_W-1:0] adj_rd_port,
    input  logic [47:0]       adj_rd_dmac,
    input  logic [MTU_W-1:0]  adj_rd_mtu,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_drop,
    output logic [1:0]        out_src,
    output logic [PLEN_W-1:0] out_plen,
    output logic              out_multi,
    output logic [ADJ_W-1:0]  out_adj_ptr,
    output logic [PORT_W-1:0] out_port,
    output logic [47:0]       out_dmac,
    output logic [MTU_W-1:0]  out_mtu,
    output logic [VRF_W-1:0]  out_vrf,
    output logic [ADDR_W-1:0] out_addr
);

    localparam int V4_LEN = 32;

    typedef struct packed {
        logic [VRF_W-1:0]  vrf;
        logic [ADDR_W-1:0] addr;
        win_src_e          src;
        logic [PLEN_W-1:0] plen;
        logic              multi;
        logic [RES_W-1:0]  idx;
        logic [GRP_W-1:0]  grp;
        logic [HASH_W-1:0] hash;
    } stage1_t;

    typedef struct packed {
        logic [VRF_W-1:0]  vrf;
        logic [ADDR_W-1:0] addr;
        win_src_e          src;
        logic [PLEN_W-1:0] plen;
        logic              multi;
        logic [ADJ_W-1:0]  ptr;
    } stage2_t;

    logic    s1_valid, s2_valid, advance;
    stage1_t s1_q, s1_d;
    stage2_t s2_q, s2_d;

    win_src_e          arb_src;
    logic [PLEN_W-1:0] arb_len;
    logic              arb_multi;
    logic [RES_W-1:0]  arb_idx;
    logic [GRP_W-1:0]  arb_grp;

    rrs_arbiter #(
        .RES_W(RES_W), .GRP_W(GRP_W), .PLEN_W(PLEN_W),
        .V4_LEN(V4_LEN), .V6_LEN(ADDR_W)
    ) u_arb (
        .in_v6(in_v6),
        .host_hit(host_hit), .host_multi(host_multi), .host_idx(host_idx), .host_grp(host_grp),
        .pfx_hit(pfx_hit), .pfx_len(pfx_len), .pfx_multi(pfx_multi), .pfx_idx(pfx_idx), .pfx_grp(pfx_grp),
        .win_src(arb_src), .win_len(arb_len), .win_multi(arb_multi), .win_idx(arb_idx), .win_grp(arb_grp)
    );

    rrs_ecmp_pick #(
        .ECMP_W(ECMP_W), .GRP_W(GRP_W), .HASH_W(HASH_W)
    ) u_pick (
        .base(s1_q.idx[ECMP_W-1:0]),
        .grp(s1_q.grp),
        .hash(s1_q.hash),
        .member_addr(ecmp_rd_addr)
    );

    // Whole pipeline moves together; a held output freezes both stages.
    assign advance  = !s2_valid || out_ready;
    assign in_ready = advance;

    always_comb begin
        s1_d.vrf   = in_vrf;
        s1_d.addr  = in_addr;
        s1_d.src   = arb_src;
        s1_d.plen  = arb_len;
        s1_d.multi = arb_multi;
        s1_d.idx   = arb_idx;
        s1_d.grp   = arb_grp;
        s1_d.hash  = in_hash;

        s2_d.vrf   = s1_q.vrf;
        s2_d.addr  = s1_q.addr;
        s2_d.src   = s1_q.src;
        s2_d.plen  = s1_q.plen;
        s2_d.multi = s1_q.multi;
        s2_d.ptr   = s1_q.multi ? ecmp_rd_adj : s1_q.idx[ADJ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
        end else if (advance) begin
            s1_valid <= in_valid;
            s2_valid <= s1_valid;
        end
        if (advance) begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign adj_rd_addr = s2_q.ptr;

    always_comb begin
        out_valid   = s2_valid;
        out_drop    = (s2_q.src == SRC_NONE);
        out_src     = s2_q.src;
        out_plen    = s2_q.plen;
        out_multi   = s2_q.multi;
        out_adj_ptr = s2_q.ptr;
        out_vrf     = s2_q.vrf;
        out_addr    = s2_q.addr;
        out_port    = out_drop ? '0 : adj_rd_port;
        out_dmac    = out_drop ? '0 : adj_rd_dmac;
        out_mtu     = out_drop ? '0 : adj_rd_mtu;
    end

    AST_HOST_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_src == SRC_HOST |-> (out_plen == PLEN_W'(V4_LEN) || out_plen == PLEN_W'(ADDR_W))); // R1

    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_drop |-> !out_multi && out_adj_ptr == '0 && out_port == '0 && out_mtu == '0); // R3

    AST_MEMBER_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        s1_valid && s1_q.multi |-> (ECMP_W'(ecmp_rd_addr - s1_q.idx[ECMP_W-1:0]) <= ECMP_W'(s1_q.grp))); // R5

    AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 in_ready |=> out_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_adj_ptr) && $stable(out_src)
                                    && $stable(out_vrf) && $stable(out_addr) && $stable(out_port)); // R8

endmodule

// File: tb/route_select_test.sv
module route_select_test;

    localparam int VRF_W = 12, ADDR_W = 128, ADJ_W = 10, ECMP_W = 10, GRP_W = 4;
    localparam int HASH_W = 16, PORT_W = 8, MTU_W = 14, RES_W = 10, PLEN_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              in_valid = 1'b0, in_ready, in_v6 = 1'b0;
    logic [VRF_W-1:0]  in_vrf = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [HASH_W-1:0] in_hash = '0;
    logic              host_hit = 1'b0, host_multi = 1'b0, pfx_hit = 1'b0, pfx_multi = 1'b0;
    logic [RES_W-1:0]  host_idx = '0, pfx_idx = '0;
    logic [GRP_W-1:0]  host_grp = '0, pfx_grp = '0;
    logic [PLEN_W-1:0] pfx_len = '0;
    logic [ECMP_W-1:0] ecmp_rd_addr;
    logic [ADJ_W-1:0]  ecmp_rd_adj, adj_rd_addr;
    logic [PORT_W-1:0] adj_rd_port;
    logic [47:0]       adj_rd_dmac;
    logic [MTU_W-1:0]  adj_rd_mtu;
    logic              out_valid, out_ready = 1'b1, out_drop, out_multi;
    logic [1:0]        out_src;
    logic [PLEN_W-1:0] out_plen;
    logic [ADJ_W-1:0]  out_adj_ptr;
    logic [PORT_W-1:0] out_port;
    logic [47:0]       out_dmac;
    logic [MTU_W-1:0]  out_mtu;
    logic [VRF_W-1:0]  out_vrf;
    logic [ADDR_W-1:0] out_addr;

    route_select uut (.*);

    // Bench-side table contents, computed
    function automatic logic [ADJ_W-1:0] member_of(input logic [ECMP_W-1:0] a);
        return ADJ_W'(a * 37 + 11);
    endfunction
    function automatic logic [PORT_W-1:0] port_of(input logic [ADJ_W-1:0] p);
        return p[7:0] ^ 8'hA5;
    endfunction
    function automatic logic [47:0] dmac_of(input logic [ADJ_W-1:0] p);
        return {16'h02AB, 22'h0, p};
    endfunction
    function automatic logic [MTU_W-1:0] mtu_of(input logic [ADJ_W-1:0] p);
        return MTU_W'(1000) + MTU_W'(p);
    endfunction

    always_comb begin
        ecmp_rd_adj = member_of(ecmp_rd_addr);
        adj_rd_port = port_of(adj_rd_addr);
        adj_rd_dmac = dmac_of(adj_rd_addr);
        adj_rd_mtu  = mtu_of(adj_rd_addr);
    end

    typedef struct {
        logic              drop;
        logic [1:0]        src;
        logic [PLEN_W-1:0] plen;
        logic              multi;
        logic [ADJ_W-1:0]  ptr;
        logic [VRF_W-1:0]  vrf;
        logic [ADDR_W-1:0] addr;
        int                due;
        bit                lat;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, fails = 0, cyc = 0;
    bit   lat_on = 1'b1;
    logic [ADJ_W-1:0] last_ptr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic send(input logic [VRF_W-1:0] vrf, input logic [ADDR_W-1:0] addr, input logic v6,
                        input logic [HASH_W-1:0] hash,
                        input logic hh, input logic hm, input logic [RES_W-1:0] hi, input logic [GRP_W-1:0] hg,
                        input logic ph, input logic [PLEN_W-1:0] pl, input logic pm,
                        input logic [RES_W-1:0] pi, input logic [GRP_W-1:0] pg);
        exp_t e;
        logic              m;
        logic [RES_W-1:0]  ix;
        logic [GRP_W-1:0]  g;
        logic [ECMP_W-1:0] ma;
        @(negedge clk);
        in_valid = 1'b1; in_vrf = vrf; in_addr = addr; in_v6 = v6; in_hash = hash;
        host_hit = hh; host_multi = hm; host_idx = hi; host_grp = hg;
        pfx_hit = ph; pfx_len = pl; pfx_multi = pm; pfx_idx = pi; pfx_grp = pg;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        e.vrf = vrf; e.addr = addr; e.due = cyc + 2; e.lat = lat_on;
        m = 1'b0; ix = '0; g = '0;
        if (hh) begin
            e.src = 2'd1; e.plen = v6 ? 8'd128 : 8'd32; m = hm; ix = hi; g = hg; e.tag = "R1";
        end else if (ph) begin
            e.src = 2'd2; e.plen = pl; m = pm; ix = pi; g = pg; e.tag = "R2";
        end else begin
            e.src = 2'd0; e.plen = '0; e.tag = "R3";
        end
        e.drop = !(hh || ph);
        e.multi = m;
        if (e.drop) e.ptr = '0;
        else if (m) begin
            ma = ECMP_W'(ix + RES_W'(hash % (32'(g) + 1)));
            e.ptr = member_of(ma);
        end else e.ptr = ix[ADJ_W-1:0];
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic              held = 1'b0;
    logic [ADJ_W-1:0]  h_ptr;
    logic [1:0]        h_src;
    logic [VRF_W-1:0]  h_vrf;
    logic [PORT_W-1:0] h_port;

    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid && !out_ready) begin
                chk(in_ready == 1'b0, "R8", "in_ready during stall", 128'(in_ready), 128'(0));
                if (held) begin
                    chk(out_adj_ptr == h_ptr && out_src == h_src && out_vrf == h_vrf && out_port == h_port,
                        "R8", "held output ptr", 128'(out_adj_ptr), 128'(h_ptr));
                end
                held = 1'b1; h_ptr = out_adj_ptr; h_src = out_src; h_vrf = out_vrf; h_port = out_port;
            end else held = 1'b0;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected result", 128'(out_vrf), 128'(0));
                end else begin
                    exp_t e;
                    string ptag;
                    e = exp_q.pop_front();
                    ptag = e.drop ? "R3" : (e.multi ? "R5" : "R4");
                    chk(out_src == e.src, e.tag, "src", 128'(out_src), 128'(e.src));
                    chk(out_drop == e.drop, "R3", "drop", 128'(out_drop), 128'(e.drop));
                    chk(out_plen == e.plen, e.tag, "plen", 128'(out_plen), 128'(e.plen));
                    chk(out_multi == e.multi, ptag, "multi", 128'(out_multi), 128'(e.multi));
                    chk(out_adj_ptr == e.ptr, ptag, "adj ptr", 128'(out_adj_ptr), 128'(e.ptr));
                    chk(out_port == (e.drop ? 8'h0 : port_of(e.ptr)), ptag, "port",
                        128'(out_port), 128'(e.drop ? 8'h0 : port_of(e.ptr)));
                    chk(out_dmac == (e.drop ? 48'h0 : dmac_of(e.ptr)), ptag, "dmac",
                        128'(out_dmac), 128'(e.drop ? 48'h0 : dmac_of(e.ptr)));
                    chk(out_mtu == (e.drop ? 14'h0 : mtu_of(e.ptr)), ptag, "mtu",
                        128'(out_mtu), 128'(e.drop ? 14'h0 : mtu_of(e.ptr)));
                    chk(out_vrf == e.vrf && out_addr == e.addr, "R10", "key echo",
                        out_addr, e.addr);
                    if (e.lat)
                        chk(cyc == e.due, "R7", "latency cycle", 128'(cyc), 128'(e.due));
                    last_ptr = out_adj_ptr;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [ADJ_W-1:0] flow_a;
        int unsigned lcg;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R9", "out_valid in reset", 128'(out_valid), 128'(0));
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R9", "out_valid after reset", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R9", "in_ready after reset", 128'(in_ready), 128'(1));

        // R1: host only, IPv4, single path
        send(12'h011, 128'hC0A80101, 1'b0, 16'h1234, 1, 0, 10'd77, 4'd0, 0, 8'd0, 0, 10'd0, 4'd0);
        // R1: host and prefix both hit, host multipath wins
        send(12'h012, 128'h0A000005, 1'b0, 16'h0031, 1, 1, 10'd100, 4'd3, 1, 8'd24, 0, 10'd9, 4'd0);
        // R1: IPv6 host hit
        send(12'h013, 128'h20010DB8000000000000000000000001, 1'b1, 16'h0007, 1, 0, 10'd300, 4'd0, 1, 8'd64, 0, 10'd5, 4'd0);
        // R2/R4: prefix only /24 single
        send(12'h014, 128'h0A010203, 1'b0, 16'h0, 0, 0, 10'd0, 4'd0, 1, 8'd24, 0, 10'd512, 4'd0);
        // R2: /16 prefix, multipath six members, hash multiple of 6
        send(12'h015, 128'hAC100001, 1'b0, 16'd600, 0, 0, 10'd0, 4'd0, 1, 8'd16, 1, 10'd200, 4'd5);
        // R5: all-ones hash
        send(12'h016, 128'hAC100002, 1'b0, 16'hFFFF, 0, 0, 10'd0, 4'd0, 1, 8'd16, 1, 10'd200, 4'd5);
        // R5: base near the top wraps
        send(12'h017, 128'hAC100003, 1'b0, 16'd5, 0, 0, 10'd0, 4'd0, 1, 8'd20, 1, 10'd1020, 4'd7);
        // R5: one-member group
        send(12'h018, 128'hAC100004, 1'b0, 16'hBEEF, 0, 0, 10'd0, 4'd0, 1, 8'd8, 1, 10'd40, 4'd0);
        // R3: miss
        send(12'h019, 128'h08080808, 1'b0, 16'h4444, 0, 1, 10'd55, 4'd2, 0, 8'd12, 1, 10'd66, 4'd2);
        // R5: sixteen-member group
        send(12'h01A, 128'hAC100005, 1'b0, 16'd47, 1, 1, 10'd500, 4'd15, 0, 8'd0, 0, 10'd0, 4'd0);
        idle();
        drain();

        // R6: same flow twice, different keys, same group
        send(12'h021, 128'h01010101, 1'b0, 16'h5A5A, 0, 0, 10'd0, 4'd0, 1, 8'd24, 1, 10'd700, 4'd9);
        idle();
        drain();
        flow_a = last_ptr;
        send(12'h022, 128'h01010177, 1'b0, 16'h5A5A, 0, 0, 10'd0, 4'd0, 1, 8'd24, 1, 10'd700, 4'd9);
        idle();
        drain();
        chk(last_ptr == flow_a, "R6", "same flow same member", 128'(last_ptr), 128'(flow_a));

        // R8: stalls with a full pipeline
        lat_on = 1'b0;
        fork
            begin
                for (int i = 0; i < 8; i++)
                    send(12'h100 + 12'(i), 128'(i * 3 + 1), 1'b0, 16'(i * 13),
                         1'(i % 3 == 0), 1'(i % 2), 10'(i * 50), 4'(i),
                         1'(i % 3 != 2), 8'(8 + i), 1'(i % 2 == 0), 10'(i * 90), 4'(i + 2));
                idle();
            end
            begin
                @(negedge clk); @(negedge clk);
                out_ready = 1'b0; repeat (4) @(negedge clk);
                out_ready = 1'b1; @(negedge clk);
                out_ready = 1'b0; repeat (2) @(negedge clk);
                out_ready = 1'b1; repeat (2) @(negedge clk);
                out_ready = 1'b0; repeat (3) @(negedge clk);
                out_ready = 1'b1;
            end
        join
        drain();
        lat_on = 1'b1;

        // R7: back-to-back mixed stream
        lcg = 32'h1357;
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 1103515245 + 12345;
            send(12'(lcg >> 4), {96'h0, lcg}, lcg[3], lcg[31:16],
                 lcg[5], lcg[6], 10'(lcg >> 7), 4'(lcg >> 17),
                 lcg[8], 8'(lcg[14:9] % 33), lcg[9], 10'(lcg >> 19), 4'(lcg >> 27));
        end
        idle();
        drain();
        chk(exp_q.size() == 0, "R7", "all results returned", 128'(exp_q.size()), 128'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule